// File: doc/BRIEF.md
# SPI command master for CAN controller

This block lets a host register interface talk to an external stand-alone CAN controller over SPI. The host sets an instruction byte, a register address byte and a data byte, then pulses `start`. The block lowers chip select and sends the three bytes as one 24-bit burst. While it shifts, it reads MISO, so a read command returns the controller's reply byte. It then raises chip select again and pulses `done`.

The block only carries bytes. It never creates a command of its own, and each accepted strobe gives exactly one frame. The serial clock comes from dividing the system clock. The divider is set by two parameters, the system clock rate and the highest SCK rate allowed. The defaults (8300 kHz, 1000 kHz) give a divide of 9, about 922 kHz. The serial link is much slower than the host side, so `busy` stays high for the whole burst.

Top module: `can_spi_cmd_master`

## Requirements
- R1: A frame is 24 bits sent on `spi_mosi` most significant bit first: `cmd_instr` first, then `cmd_addr`, then `cmd_data`, one bit per SCK rising edge, exactly 24 rising edges per frame.
- R2: SPI mode 0: `spi_sck` is low whenever `spi_cs_n` is high, and `spi_mosi` never changes while `spi_sck` is high. `spi_miso` is sampled at each SCK rising edge.
- R3: With DIV = max(2, ceil(SYS_CLK_KHZ / SCK_MAX_KHZ)), each bit has a low phase of DIV - DIV/2 system clocks followed by a high phase of DIV/2 system clocks. Successive SCK rising edges are therefore DIV clocks apart.
- R4: `spi_cs_n` goes low in the first cycle after `start` is accepted. It stays low for one low phase (DIV - DIV/2 clocks) before the first SCK rise. It returns high one low phase after the last SCK fall.
- R5: `busy` is high from the cycle after `start` is accepted until `spi_cs_n` rises, a total of 24*DIV + (DIV - DIV/2) cycles.
- R6: At the end of a frame, `rx_byte` takes the last 8 bits sampled from MISO, first-sampled bit as the MSB. It keeps that value until the next frame ends.
- R7: `done` is high for exactly one system clock per frame, in the same cycle that `spi_cs_n` returns high.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The frame in flight keeps its original bytes and length, and no extra frame follows.
- R9: While reset is held and right after it is released: `spi_cs_n` = 1, `spi_sck` = 0, `spi_mosi` = 0, `busy` = 0, `done` = 0 and `rx_byte` = 0.
- R10: Without a `start` pulse the block stays idle: `spi_cs_n` remains high and no SCK edge appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe that begins a frame; ignored while busy |
| cmd_instr | input | 8 | Instruction byte, sent first |
| cmd_addr | input | 8 | Register address byte, sent second |
| cmd_data | input | 8 | Data byte, sent third |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| rx_byte | output | 8 | Last byte sampled from MISO |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the controller |
| spi_miso | input | 1 | Serial data from the controller |

## Verification
The bench builds the block with a 3000 kHz system clock and a 1000 kHz SCK limit. That gives DIV = 3, an odd ratio, so the low phase (2 clocks) and the high phase (1 clock) differ. Phase-length mistakes and swapped phase choices then show up in the edge spacing. The short divide keeps each frame at 74 cycles, so many byte patterns, an ignored mid-frame strobe and the idle behaviour all fit in a short run. The bench's own SPI slave model catches each MOSI bit at every SCK rise and drives MISO after each fall.

// File: rtl/can_spi_pkg.sv
package can_spi_pkg;

    localparam int FRAME_BITS = 24;
    localparam int BYTE_W     = 8;
    localparam int BIT_IDX_W  = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_TAIL = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e            state;
        logic                  sck;
        logic                  cs_n;
        logic                  done;
        logic [BYTE_W-1:0]     rx_byte;
        logic [BIT_IDX_W-1:0]  bit_idx;
    } seq_regs_t;

endpackage

// File: rtl/can_spi_phase_timer.sv
module can_spi_phase_timer #(
    parameter int LO_LEN = 5,
    parameter int HI_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hi_sel,
    output logic expire
);

    localparam int MAX_LEN = (LO_LEN > HI_LEN) ? LO_LEN : HI_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit  = hi_sel ? CNT_W'(HI_LEN - 1) : CNT_W'(LO_LEN - 1);
        expire = run && (cnt_q == limit);
        if (!run || expire) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(MAX_LEN));

endmodule

// File: rtl/can_spi_shifter.sv
module can_spi_shifter #(
    parameter int FRAME_BITS = 24,
    parameter int RX_BITS    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_word,
    input  logic                  shift_out,
    input  logic                  sample_in,
    input  logic                  miso,
    output logic                  mosi,
    output logic [RX_BITS-1:0]    rx_word
);

    logic [FRAME_BITS-1:0] tx_d, tx_q;
    logic [RX_BITS-1:0]    rx_d, rx_q;

    always_comb begin
        tx_d = tx_q;
        rx_d = rx_q;
        if (load) begin
            tx_d = load_word;
        end else if (shift_out) begin
            tx_d = {tx_q[FRAME_BITS-2:0], 1'b0};
        end
        if (sample_in) begin
            rx_d = {rx_q[RX_BITS-2:0], miso};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            tx_q <= tx_d;
            rx_q <= rx_d;
        end
    end

    assign mosi    = tx_q[FRAME_BITS-1];
    assign rx_word = rx_q;

    // R1
    load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift_out));

    // R2
    shift_sample_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_out && sample_in));

endmodule

// File: rtl/can_spi_cmd_master.sv
module can_spi_cmd_master
    import can_spi_pkg::*;
#(
    parameter int SYS_CLK_KHZ = 8300,
    parameter int SCK_MAX_KHZ = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] cmd_instr,
    input  logic [BYTE_W-1:0] cmd_addr,
    input  logic [BYTE_W-1:0] cmd_data,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int DIV_RAW = (SYS_CLK_KHZ + SCK_MAX_KHZ - 1) / SCK_MAX_KHZ;
    localparam int DIV     = (DIV_RAW < 2) ? 2 : DIV_RAW;
    localparam int HI_LEN  = DIV / 2;
    localparam int LO_LEN  = DIV - HI_LEN;

    seq_regs_t r_d, r_q;

    logic              expire;
    logic              load;
    logic              shift_out;
    logic              sample_in;
    logic [BYTE_W-1:0] rx_word;

    can_spi_phase_timer #(
        .LO_LEN (LO_LEN),
        .HI_LEN (HI_LEN)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (r_q.state != ST_IDLE),
        .hi_sel (r_q.state == ST_HIGH),
        .expire (expire)
    );

    can_spi_shifter #(
        .FRAME_BITS (FRAME_BITS),
        .RX_BITS    (BYTE_W)
    ) i_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word ({cmd_instr, cmd_addr, cmd_data}),
        .shift_out (shift_out),
        .sample_in (sample_in),
        .miso      (spi_miso),
        .mosi      (spi_mosi),
        .rx_word   (rx_word)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        load      = 1'b0;
        shift_out = 1'b0;
        sample_in = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    load        = 1'b1;
                    r_d.state   = ST_LOW;
                    r_d.cs_n    = 1'b0;
                    r_d.bit_idx = '0;
                end
            end
            ST_LOW: begin
                if (expire) begin
                    sample_in = 1'b1;
                    r_d.sck   = 1'b1;
                    r_d.state = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (expire) begin
                    r_d.sck = 1'b0;
                    if (r_q.bit_idx == BIT_IDX_W'(FRAME_BITS - 1)) begin
                        r_d.state = ST_TAIL;
                    end else begin
                        shift_out   = 1'b1;
                        r_d.bit_idx = r_q.bit_idx + 1'b1;
                        r_d.state   = ST_LOW;
                    end
                end
            end
            ST_TAIL: begin
                if (expire) begin
                    r_d.state   = ST_IDLE;
                    r_d.cs_n    = 1'b1;
                    r_d.done    = 1'b1;
                    r_d.rx_byte = rx_word;
                    r_d.bit_idx = '0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.sck     <= 1'b0;
            r_q.cs_n    <= 1'b1;
            r_q.done    <= 1'b0;
            r_q.rx_byte <= '0;
            r_q.bit_idx <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.state != ST_IDLE);
    assign done     = r_q.done;
    assign rx_byte  = r_q.rx_byte;
    assign spi_sck  = r_q.sck;
    assign spi_cs_n = r_q.cs_n;

    // R2
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> done);

    // R8
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(r_q.state == ST_TAIL && expire)) |=> !spi_cs_n);

    // R1
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.bit_idx < BIT_IDX_W'(FRAME_BITS));

    // R2
    mosi_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

endmodule

// File: tb/test_can_spi_cmd_master.sv
module test_can_spi_cmd_master;

    localparam int SYS_KHZ   = 3000;
    localparam int SCK_KHZ   = 1000;
    localparam int DIV_EXP   = 3;
    localparam int LO_EXP    = 2;
    localparam int HI_EXP    = 1;
    localparam int FRAME_EXP = 24 * DIV_EXP + LO_EXP;
    localparam int NVEC      = 5;

    // instr, addr, data, 24-bit MISO response
    localparam logic [47:0] VEC [NVEC] = '{
        48'h00_00_00_FFFFFF,
        48'hFF_FF_FF_000000,
        48'h03_2A_00_0000A5,
        48'h02_31_5A_123456,
        48'hA5_5A_C3_800001
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] cmd_instr = '0;
    logic [7:0] cmd_addr = '0;
    logic [7:0] cmd_data = '0;
    logic       busy, done, spi_sck, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;
    logic [7:0] rx_byte;

    int errs = 0;
    int checks = 0;

    always #4 clk = ~clk;

    can_spi_cmd_master #(
        .SYS_CLK_KHZ (SYS_KHZ),
        .SCK_MAX_KHZ (SCK_KHZ)
    ) i_can_spi_cmd_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_instr (cmd_instr),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .busy      (busy),
        .done      (done),
        .rx_byte   (rx_byte),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [7:0] ins, input logic [7:0] adr,
                             input logic [7:0] dat, input logic [23:0] resp,
                             input bit inject);
        logic [23:0] cap = '0;
        logic prev_sck = 1'b0;
        logic prev_mosi = 1'b0;
        int first_rise = 0, last_rise = 0, last_fall = 0, cs_rise = 0;
        int rises = 0, busy_cnt = 0, done_cnt = 0, high_cnt = 0;
        int mosi_bad = 0, done_cs_bad = 0, nb = 23, t = 1;
        @(negedge clk);
        cmd_instr = ins; cmd_addr = adr; cmd_data = dat; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R4: chip select drops in the first cycle after the strobe
        chk("R4", "cs_n after start", {31'd0, spi_cs_n}, 32'd0);
        spi_miso = resp[23];
        prev_mosi = spi_mosi;
        while (t < 400) begin
            if (inject && t == 30) begin
                cmd_instr = ~ins; cmd_addr = ~adr; cmd_data = ~dat; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (spi_sck) high_cnt++;
            if (spi_sck && !prev_sck) begin
                rises++;
                cap = {cap[22:0], spi_mosi};
                if (first_rise == 0) first_rise = t;
                last_rise = t;
            end
            if (!spi_sck && prev_sck) begin
                last_fall = t;
                if (nb > 0) begin
                    nb--;
                    spi_miso = resp[nb];
                end
            end
            if (spi_sck && prev_sck && spi_mosi !== prev_mosi) mosi_bad++;
            if (busy) busy_cnt++;
            if (done) begin
                done_cnt++;
                if (spi_cs_n !== 1'b1) done_cs_bad++;
            end
            if (spi_cs_n && cs_rise == 0) cs_rise = t;
            if (cs_rise != 0 && t == cs_rise + 3) break;
            prev_sck = spi_sck;
            prev_mosi = spi_mosi;
            t++;
            @(negedge clk);
        end
        start = 1'b0;
        if (cs_rise == 0) begin
            checks++; errs++;
            $display("FAIL R5 frame never ended: actual=%0d expected=%0d", t, FRAME_EXP);
        end
        chk("R1", "MOSI frame", {8'd0, cap}, {8'd0, ins, adr, dat});
        chk("R1", "SCK rising edges", rises, 24);
        chk("R2", "MOSI changes while SCK high", mosi_bad, 0);
        chk("R3", "rise spacing", last_rise - first_rise, 23 * DIV_EXP);
        chk("R3", "high cycles", high_cnt, 24 * HI_EXP);
        chk("R4", "cs setup", first_rise - 1, LO_EXP);
        chk("R4", "cs hold", cs_rise - last_fall, LO_EXP);
        chk("R5", "busy cycles", busy_cnt, FRAME_EXP);
        chk("R7", "done pulses", done_cnt, 1);
        chk("R7", "done with cs rise", done_cs_bad, 0);
        chk("R6", "rx_byte", {24'd0, rx_byte}, {24'd0, resp[7:0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values while reset is held
        chk("R9", "reset outputs",
            {21'd0, spi_cs_n, spi_sck, spi_mosi, busy, done, rx_byte},
            {21'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9", "post-reset outputs",
            {21'd0, spi_cs_n, spi_sck, spi_mosi, busy, done, rx_byte},
            {21'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00});

        for (int v = 0; v < NVEC; v++) begin
            run_frame(VEC[v][47:40], VEC[v][39:32], VEC[v][31:24], VEC[v][23:0], 1'b0);
        end

        // R8: strobe with other bytes mid-frame must change nothing
        run_frame(8'h5C, 8'h0F, 8'h81, 24'h00003C, 1'b1);
        begin
            int cs_low = 0, sck_hi = 0;
            // R10 and R6: idle with MISO toggling, no frame, rx_byte held
            for (int k = 0; k < 40; k++) begin
                spi_miso = k[0];
                @(negedge clk);
                if (!spi_cs_n) cs_low++;
                if (spi_sck) sck_hi++;
            end
            chk("R8", "no extra frame after ignored start", cs_low, 0);
            chk("R10", "SCK idle without start", sck_hi, 0);
            chk("R6", "rx_byte held while idle", {24'd0, rx_byte}, 32'h3C);
            chk("R10", "busy idle", {31'd0, busy}, 32'd0);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule